// File: doc/BRIEF.md
# DRAM Controller Boot Handshake Register Block

This block is a small memory-mapped register window that sits where a DRAM controller's configuration port would be during early boot. Boot firmware writes request bits to start memory initialization and data training, then polls until those bits read back as zero. It also kicks off impedance (ZQ) calibration and polls a status flag. The block answers every one of these handshakes at once, so firmware moves past its polling loops without any memory timing, PHY or refresh logic being present.

Accesses arrive on a simple one-request-per-cycle 32-bit bus with byte enables. A write takes effect on the clock edge at which it is presented. A read is answered one cycle later with a valid strobe. Three offsets are named registers. Every other offset below the out-of-range boundary reads as zero and raises an unimplemented-access pulse. Offsets from the boundary to the end of the 4 KiB window read as zero and raise an out-of-range pulse.

Top module: `dram_boot_regs`

## Requirements
- R1: After reset, the control register (byte offset 0x000) reads 0x80020000, the calibration control register (0x0A8) reads 0x07B00000 and the calibration status register (0x0B0) reads 0x80000000.
- R2: A read request produces rsp_valid high for exactly one cycle, in the cycle after the request; a write or an idle cycle never produces rsp_valid.
- R3: A full-word write to the control register stores the written value with bit 31 (initialization request) and bit 30 (training request) forced to 0, and every other bit kept as written.
- R4: A full-word write to the calibration control register stores the written value and sets bit 31 (calibration done) of the status register, leaving the other status bits unchanged.
- R5: A full-word write to the status register stores the written value as given, so bit 31 can be cleared by software.
- R6: A full-word access to any other offset below 0x2E4 reads 0, changes no named register, and raises unimpl_pulse for one cycle in the cycle after the request.
- R7: A full-word access at byte offsets 0x2E4 to 0xFFF reads 0, changes no named register, and raises oob_pulse for one cycle in the cycle after the request.
- R8: An access whose four byte enables are not all 1 is not written, reads return 0 with rsp_valid, and neither pulse is raised.
- R9: Address bits 31 to 12 and bits 1 to 0 are ignored; the register is chosen by bits 11 to 2 alone.
- R10: A write is visible to a read issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables; only 4'b1111 is a full word |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| oob_pulse | output | 1 | One-cycle pulse after a full-word access beyond 0x2E3 |
| unimpl_pulse | output | 1 | One-cycle pulse after a full-word access to an unnamed offset |

## Verification
The bench aims at the self-clearing bits with writes that set one, both or neither request bit; a design that stored them would leave firmware polling forever, and one that cleared too much would lose configuration bits. It writes the status register to a pattern with bit 31 low and then writes the calibration control register, which catches a design that replaces the status word instead of OR-ing in the done flag. It probes offsets 0x2E0 and 0x2E4 on each side of the out-of-range boundary, addresses with high bits set that alias named registers, and partial byte enables aimed at named registers, where an off-by-one compare would misroute pulses and a loose enable check would corrupt state. A long random run mixing these cases is compared cycle by cycle with a behavioural model.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    // Where a decoded access lands inside the register window.
    typedef enum logic [2:0] {
        SLOT_CTRL   = 3'd0,
        SLOT_ZQCTL  = 3'd1,
        SLOT_ZQSTAT = 3'd2,
        SLOT_SPARE  = 3'd3,
        SLOT_OOB    = 3'd4
    } slot_e;

    function automatic logic is_named(input slot_e s);
        return (s == SLOT_CTRL) || (s == SLOT_ZQCTL) || (s == SLOT_ZQSTAT);
    endfunction

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode #(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       WIN_AW     = 12,
    parameter logic [WIN_AW-1:0] CTRL_OFF   = 12'h000,
    parameter logic [WIN_AW-1:0] ZQCTL_OFF  = 12'h0A8,
    parameter logic [WIN_AW-1:0] ZQSTAT_OFF = 12'h0B0,
    parameter logic [WIN_AW-1:0] OOB_BASE   = 12'h2E4
) (
    input  logic [ADDR_W-1:0] addr,
    output dbr_pkg::slot_e    slot
);
    import dbr_pkg::*;

    localparam int unsigned IDX_W = WIN_AW - 2;

    logic [IDX_W-1:0]  word_idx;
    logic [WIN_AW-1:0] word_off;
    logic [ADDR_W-1:0] unused_addr_bits;

    assign word_idx = addr[WIN_AW-1:2];
    assign word_off = {word_idx, 2'b00};

    // Bits outside the window and the byte lane select do not steer decode.
    assign unused_addr_bits = addr;

    always_comb begin
        if (word_off >= OOB_BASE) begin
            slot = SLOT_OOB;
        end else if (word_idx == CTRL_OFF[WIN_AW-1:2]) begin
            slot = SLOT_CTRL;
        end else if (word_idx == ZQCTL_OFF[WIN_AW-1:2]) begin
            slot = SLOT_ZQCTL;
        end else if (word_idx == ZQSTAT_OFF[WIN_AW-1:2]) begin
            slot = SLOT_ZQSTAT;
        end else begin
            slot = SLOT_SPARE;
        end
    end

endmodule

// File: rtl/dbr_cfg_regs.sv
module dbr_cfg_regs #(
    parameter int unsigned       DATA_W       = 32,
    parameter logic [DATA_W-1:0] CTRL_RST     = 32'h8002_0000,
    parameter logic [DATA_W-1:0] ZQCTL_RST    = 32'h07B0_0000,
    parameter logic [DATA_W-1:0] ZQSTAT_RST   = 32'h8000_0000,
    parameter int unsigned       INIT_BIT     = 31,
    parameter int unsigned       TRAIN_BIT    = 30,
    parameter int unsigned       DONE_BIT     = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  dbr_pkg::slot_e    slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] zqctl_q,
    output logic [DATA_W-1:0] zqstat_q
);
    import dbr_pkg::*;

    localparam logic [DATA_W-1:0] REQ_MASK  =
        (DATA_W'(1) << INIT_BIT) | (DATA_W'(1) << TRAIN_BIT);
    localparam logic [DATA_W-1:0] DONE_MASK = DATA_W'(1) << DONE_BIT;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] zqctl;
        logic [DATA_W-1:0] zqstat;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (slot)
                SLOT_CTRL: begin
                    // Requests complete instantly, so they never stay set.
                    st_d.ctrl = wdata & ~REQ_MASK;
                end
                SLOT_ZQCTL: begin
                    st_d.zqctl  = wdata;
                    st_d.zqstat = st_q.zqstat | DONE_MASK;
                end
                SLOT_ZQSTAT: begin
                    st_d.zqstat = wdata;
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl   <= CTRL_RST;
            st_q.zqctl  <= ZQCTL_RST;
            st_q.zqstat <= ZQSTAT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q   = st_q.ctrl;
    assign zqctl_q  = st_q.zqctl;
    assign zqstat_q = st_q.zqstat;

    // R3
    ctrl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot == SLOT_CTRL) |=>
            ((ctrl_q & REQ_MASK) == '0) &&
            ((ctrl_q & ~REQ_MASK) == ($past(wdata) & ~REQ_MASK)));

    // R4
    zq_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot == SLOT_ZQCTL) |=>
            (zqstat_q == ($past(zqstat_q) | DONE_MASK)) && (zqctl_q == $past(wdata)));

    // R5
    zqstat_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot == SLOT_ZQSTAT) |=> (zqstat_q == $past(wdata)));

    // R6
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !is_named(slot)) |=>
            ($stable(ctrl_q) && $stable(zqctl_q) && $stable(zqstat_q)));

endmodule

// File: rtl/dbr_rsp.sv
module dbr_rsp #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              full_word,
    input  dbr_pkg::slot_e    slot,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] zqctl_q,
    input  logic [DATA_W-1:0] zqstat_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              oob_pulse,
    output logic              unimpl_pulse
);
    import dbr_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
        logic              oob;
        logic              unimpl;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = req_valid && !req_write;
        rsp_d.oob    = req_valid && full_word && (slot == SLOT_OOB);
        rsp_d.unimpl = req_valid && full_word && (slot == SLOT_SPARE);
        if (req_valid && !req_write && full_word) begin
            unique case (slot)
                SLOT_CTRL:   rsp_d.rdata = ctrl_q;
                SLOT_ZQCTL:  rsp_d.rdata = zqctl_q;
                SLOT_ZQSTAT: rsp_d.rdata = zqstat_q;
                default:     rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_rdata    = rsp_q.rdata;
    assign oob_pulse    = rsp_q.oob;
    assign unimpl_pulse = rsp_q.unimpl;

    // R2
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R7
    oob_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oob_pulse && rsp_valid) |-> (rsp_rdata == '0));

    // R6
    spare_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unimpl_pulse && rsp_valid) |-> (rsp_rdata == '0));

    // R8
    partial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !full_word) |=> (!oob_pulse && !unimpl_pulse && rsp_rdata == '0));

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({oob_pulse, unimpl_pulse}));

endmodule

// File: rtl/dram_boot_regs.sv
module dram_boot_regs #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WIN_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              oob_pulse,
    output logic              unimpl_pulse
);
    import dbr_pkg::*;

    slot_e             slot;
    logic              full_word;
    logic              wr_en;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] zqctl_q;
    logic [DATA_W-1:0] zqstat_q;

    assign full_word = &req_be;
    assign wr_en     = req_valid && req_write && full_word;

    dbr_decode #(
        .ADDR_W (ADDR_W),
        .WIN_AW (WIN_AW)
    ) i_decode (
        .addr (req_addr),
        .slot (slot)
    );

    dbr_cfg_regs #(
        .DATA_W (DATA_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .slot     (slot),
        .wdata    (req_wdata),
        .ctrl_q   (ctrl_q),
        .zqctl_q  (zqctl_q),
        .zqstat_q (zqstat_q)
    );

    dbr_rsp #(
        .DATA_W (DATA_W)
    ) i_rsp (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .full_word    (full_word),
        .slot         (slot),
        .ctrl_q       (ctrl_q),
        .zqctl_q      (zqctl_q),
        .zqstat_q     (zqstat_q),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .oob_pulse    (oob_pulse),
        .unimpl_pulse (unimpl_pulse)
    );

endmodule

// File: tb/test_dram_boot_regs.sv
module test_dram_boot_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        oob_pulse;
    logic        unimpl_pulse;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Behavioural reference state
    logic [31:0] m_ctrl, m_zqctl, m_zqstat;
    logic        e_valid, e_oob, e_unimpl;
    logic [31:0] e_rdata;
    string       e_tag;

    always #10ns clk = ~clk;

    dram_boot_regs i_dram_boot_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_be       (req_be),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .oob_pulse    (oob_pulse),
        .unimpl_pulse (unimpl_pulse)
    );

    task automatic compare();
        vectors++;
        if (rsp_valid !== e_valid || oob_pulse !== e_oob || unimpl_pulse !== e_unimpl ||
            (e_valid && rsp_rdata !== e_rdata)) begin
            errors++;
            $display("FAIL %s: valid/oob/unimpl/rdata = %b/%b/%b/%h, expected %b/%b/%b/%h",
                     e_tag, rsp_valid, oob_pulse, unimpl_pulse, rsp_rdata,
                     e_valid, e_oob, e_unimpl, e_rdata);
        end
    endtask

    // One bus cycle: check the outputs caused by the previous cycle, then drive this one.
    task automatic step(input bit v, input bit w, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] be, input string tag);
        logic [11:0] off;
        bit full;
        @(negedge clk);
        compare();
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        off  = {a[11:2], 2'b00};
        full = (be == 4'hF);
        e_tag = tag; e_valid = v && !w; e_rdata = 32'h0; e_oob = 1'b0; e_unimpl = 1'b0;
        if (v && full) begin
            if (off >= 12'h2E4) e_oob = 1'b1;
            else if (off != 12'h000 && off != 12'h0A8 && off != 12'h0B0) e_unimpl = 1'b1;
            if (!w) begin
                if (off == 12'h000) e_rdata = m_ctrl;
                else if (off == 12'h0A8) e_rdata = m_zqctl;
                else if (off == 12'h0B0) e_rdata = m_zqstat;
            end else begin
                if (off == 12'h000) m_ctrl = d & 32'h3FFF_FFFF;
                else if (off == 12'h0A8) begin m_zqctl = d; m_zqstat[31] = 1'b1; end
                else if (off == 12'h0B0) m_zqstat = d;
            end
        end
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        step(1'b1, 1'b0, a, $urandom, 4'hF, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, 4'hF, tag);
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        m_ctrl = 32'h8002_0000; m_zqctl = 32'h07B0_0000; m_zqstat = 32'h8000_0000;
        e_valid = 0; e_oob = 0; e_unimpl = 0; e_rdata = 0; e_tag = "R1 reset idle";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1 idle");
        // R1 reset values
        rd(32'h000, "R1 ctrl reset");
        rd(32'h0A8, "R1 zqctl reset");
        rd(32'h0B0, "R1 zqstat reset");
        // R9 aliasing through high address bits and byte lane bits
        rd(32'hABCD_E0A8, "R9 high bits alias zqctl");
        rd(32'h0000_00B3, "R9 low bits ignored");
        // R3 self-clearing request bits, R10 back-to-back visibility
        wr(32'h000, 32'hFFFF_FFFF, "R3 both requests");
        rd(32'h000, "R10 read right after write");
        wr(32'h000, 32'h4000_1234, "R3 training request");
        rd(32'h000, "R3 training cleared");
        wr(32'h000, 32'h8000_00AA, "R3 init request");
        rd(32'h000, "R3 init cleared");
        wr(32'h000, 32'h0012_3456, "R3 no request");
        rd(32'h000, "R3 plain value kept");
        // R5 status stored as written; R4 done flag OR-ed in
        wr(32'h0B0, 32'h0000_0055, "R5 status write");
        rd(32'h0B0, "R5 status readback");
        wr(32'h0A8, 32'h1234_5678, "R4 zqctl write");
        rd(32'h0A8, "R4 zqctl readback");
        rd(32'h0B0, "R4 done flag set");
        // R6 unnamed offsets
        rd(32'h004, "R6 spare read");
        rd(32'h2E0, "R6 last spare word");
        wr(32'h0AC, 32'hDEAD_BEEF, "R6 spare write");
        rd(32'h0A8, "R6 zqctl untouched");
        rd(32'h0B0, "R6 zqstat untouched");
        // R7 out-of-range window
        rd(32'h2E4, "R7 first oob word");
        rd(32'hFFC, "R7 last oob word");
        wr(32'h2E4, 32'hFFFF_FFFF, "R7 oob write");
        rd(32'h000, "R7 ctrl untouched");
        // R8 partial byte enables
        step(1, 0, 32'h000, 0, 4'h7, "R8 partial read");
        step(1, 1, 32'h000, 32'hFFFF_0000, 4'hE, "R8 partial write");
        step(1, 1, 32'h2E4, 32'h1, 4'h1, "R8 partial oob write");
        rd(32'h000, "R8 ctrl untouched");
        // R2 idle and writes give no response
        step(0, 1, 32'h000, 32'h1, 4'hF, "R2 idle with write set");
        step(0, 0, 0, 0, 0, "R2 idle");
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            int k;
            k = $urandom_range(0, 6);
            case (k)
                0: a = 32'h000;
                1: a = 32'h0A8;
                2: a = 32'h0B0;
                3: a = 32'h2E0;
                4: a = 32'h2E4;
                5: a = {$urandom} & 32'hFFFF_FFFC;
                default: a = ($urandom & 32'hFFFF_F000) | 32'h0A8;
            endcase
            step($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, a, $urandom,
                 ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'hF, "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end
        step(0, 0, 0, 0, 0, "R2 drain");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule